// File: doc/BRIEF.md
# Four-Pin I/O Expander Register Core

This core holds the register file and pin control for a four-pin general-purpose I/O expander. A byte-oriented host reaches it through three strobes. `cmd_valid` loads a register pointer. `wr_valid` writes a data byte to the register the pointer selects. `rd_req` marks that the host has taken a read of that register. The read byte is shown combinationally on `rd_data` for the register the pointer currently selects. Serial bus framing lives outside this core.

There are five register addresses. Address 0x00 gives an input view of the pins. Address 0x01 holds the output levels. Address 0x02 holds the input inversion mask. Address 0x03 sets pin direction. Address 0x50 (parameter `SPECIAL_ADDR`) holds two mode bits. Bit 7 turns pin 3 into an active-low, open-drain change-alert output. Bit 6 turns off the pull-up enable. Pins are sampled through one register stage before anything uses them.

Top module: `gpio4_expander_core`

## Requirements
- R1: After reset, the pointer is 0x00. Reads return 0xFF at 0x01, 0x00 at 0x02, 0xFF at 0x03 and 0x00 at 0x50. All `pin_oe` bits are 0 and `pullup_en` is 1.
- R2: A `cmd_valid` cycle loads `host_data_in` into the pointer. From the next cycle on, `rd_data` shows the register that was selected.
- R3: A read of 0x00 returns 1111 in bits 7:4. Bits 3:0 return each pin level sampled one clock earlier, whatever the pin's direction. Writes to 0x00 change no register.
- R4: In the 0x00 view, bit i is inverted when bit i of register 0x02 is 1 and pin i is an input. Pins set as outputs are never inverted.
- R5: Register 0x01 resets to all ones. A read of it returns the stored bits (bits 7:4 read 1), not the pin levels. `pin_out[i]` follows its bit i, but only pins set as outputs are driven.
- R6: In register 0x03, bit i = 1 makes pin i an input with `pin_oe[i]` = 0. Bit i = 0 makes pin i an output with `pin_oe[i]` = 1.
- R7: Bit 6 of register 0x50 set to 1 drives `pullup_en` to 0. When the bit is 0, `pullup_en` is 1.
- R8: When bit 7 of register 0x50 is 1, pin 3 has `pin_out[3]` = 0. `pin_oe[3]` is 1 while any input pin among 0..2 differs from a reference value. The reference is all ones after reset and is reloaded from the sampled pins on each `rd_req` while the pointer is 0x00, which releases pin 3.
- R9: A command byte that matches no register is still accepted as the pointer. Reads then return 0xFF and writes change nothing.
- R10: Unused bits are fixed. Bits 7:4 of 0x02 read 0 and bits 7:4 of 0x01 and 0x03 read 1. Bits 5:0 of 0x50 read 0. Writes to these bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Load `host_data_in` as the register pointer |
| wr_valid | input | 1 | Write `host_data_in` to the selected register |
| rd_req | input | 1 | Host has taken a read of the selected register |
| host_data_in | input | 8 | Command or data byte from the host |
| rd_data | output | 8 | Content of the selected register |
| pin_in | input | 4 | Pin levels seen at the pads |
| pin_out | output | 4 | Level driven on each pin |
| pin_oe | output | 4 | Output enable for each pin |
| pullup_en | output | 1 | Enable for the pin pull-ups |

## Verification
The assertions assume that the host raises at most one of `cmd_valid`, `wr_valid` and `rd_req` in any cycle. The bench changes each strobe on the falling edge and drops it one cycle later, so no two strobes ever overlap. The interrupt-release check also assumes the pins hold still across the read cycle. Each bench scenario changes pins only on a falling edge, and never in the cycle in which it pulses `rd_req`.

// File: rtl/gpio4_expander_core.sv
module gpio4_expander_core #(
  parameter logic [7:0] SPECIAL_ADDR = 8'h50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       wr_valid,
  input  logic       rd_req,
  input  logic [7:0] host_data_in,
  output logic [7:0] rd_data,
  input  logic [3:0] pin_in,
  output logic [3:0] pin_out,
  output logic [3:0] pin_oe,
  output logic       pullup_en
);

  logic [7:0] ptr;
  logic [3:0] out_r, inv_r, dir_r, pin_q, ref_q;
  logic [1:0] mode_r;

  wire       alert_mode = mode_r[1];
  wire [3:0] in_view    = pin_q ^ (inv_r & dir_r);
  wire [3:0] cmp_mask   = dir_r & {~alert_mode, 3'b111};
  wire       alert_act  = |((pin_q ^ ref_q) & cmp_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= 8'h00;
      out_r  <= 4'hF;
      inv_r  <= 4'h0;
      dir_r  <= 4'hF;
      mode_r <= 2'b00;
      pin_q  <= 4'hF;
      ref_q  <= 4'hF;
    end else begin
      pin_q <= pin_in;
      if (cmd_valid)
        ptr <= host_data_in;
      else if (wr_valid) begin
        if (ptr == 8'h01)              out_r  <= host_data_in[3:0];
        else if (ptr == 8'h02)         inv_r  <= host_data_in[3:0];
        else if (ptr == 8'h03)         dir_r  <= host_data_in[3:0];
        else if (ptr == SPECIAL_ADDR)  mode_r <= host_data_in[7:6];
      end
      if (rd_req && ptr == 8'h00)
        ref_q <= pin_q;
    end
  end

  always_comb begin
    if (ptr == 8'h00)              rd_data = {4'hF, in_view};
    else if (ptr == 8'h01)         rd_data = {4'hF, out_r};
    else if (ptr == 8'h02)         rd_data = {4'h0, inv_r};
    else if (ptr == 8'h03)         rd_data = {4'hF, dir_r};
    else if (ptr == SPECIAL_ADDR)  rd_data = {mode_r, 6'b0};
    else                           rd_data = 8'hFF;
  end

  assign pin_out   = {out_r[3] & ~alert_mode, out_r[2:0]};
  assign pin_oe    = {alert_mode ? alert_act : ~dir_r[3], ~dir_r[2:0]};
  assign pullup_en = ~mode_r[0];

  AST_INPUT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !cmd_valid && ptr == 8'h00) |=>
      ($stable(out_r) && $stable(inv_r) && $stable(dir_r) && $stable(mode_r))); // R3

  AST_DIR_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !cmd_valid && ptr == 8'h03) |=>
      (pin_oe[2:0] == ~$past(host_data_in[2:0]))); // R6

  AST_PULLUP_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !cmd_valid && ptr == SPECIAL_ADDR) |=>
      (pullup_en == !$past(host_data_in[6]))); // R7

  AST_ALERT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    alert_mode |-> !pin_out[3]); // R8

  AST_ALERT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !cmd_valid && !wr_valid && ptr == 8'h00 && alert_mode && pin_in == pin_q)
      |=> !pin_oe[3]); // R8

  AST_UNKNOWN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && host_data_in > 8'h03 && host_data_in != SPECIAL_ADDR) |=>
      (rd_data == 8'hFF)); // R9

endmodule

// File: tb/test_gpio4_expander_core.sv
module test_gpio4_expander_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
  logic [7:0] host_data_in = 8'h00;
  logic [7:0] rd_data;
  logic [3:0] pin_in = 4'hF;
  logic [3:0] pin_out, pin_oe;
  logic       pullup_en;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  gpio4_expander_core i_gpio4_expander_core (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .wr_valid(wr_valid),
    .rd_req(rd_req), .host_data_in(host_data_in), .rd_data(rd_data),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pullup_en(pullup_en)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp_v);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pin_in = 4'hF;
    cmd_valid = 1'b0; wr_valid = 1'b0; rd_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_cmd(input logic [7:0] b);
    cmd_valid = 1'b1; host_data_in = b; @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic do_wr(input logic [7:0] b);
    wr_valid = 1'b1; host_data_in = b; @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic do_rd();
    rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ptr0 view", rd_data, 8'hFF);
    chk("R1 oe", {4'h0, pin_oe}, 8'h00);
    chk("R1 pullup", {7'd0, pullup_en}, 8'h01);
    do_cmd(8'h01); chk("R1 R2 out reg", rd_data, 8'hFF);
    do_cmd(8'h02); chk("R1 R2 inv reg", rd_data, 8'h00);
    do_cmd(8'h03); chk("R1 R2 dir reg", rd_data, 8'hFF);
    do_cmd(8'h50); chk("R1 R2 special reg", rd_data, 8'h00);
  endtask

  task automatic t_input();
    do_reset();
    pin_in = 4'hA; @(negedge clk);
    chk("R3 view inputs", rd_data, 8'hFA);
    do_wr(8'h00);
    do_cmd(8'h01); chk("R3 write ignored out", rd_data, 8'hFF);
    do_cmd(8'h03); chk("R3 write ignored dir", rd_data, 8'hFF);
    do_wr(8'hFC);
    do_cmd(8'h00); chk("R3 view with outputs", rd_data, 8'hFA);
  endtask

  task automatic t_polarity();
    do_reset();
    pin_in = 4'hA;
    do_cmd(8'h03); do_wr(8'hFC);
    do_cmd(8'h02); do_wr(8'h0F);
    do_cmd(8'h00); chk("R4 inverted inputs only", rd_data, 8'hF6);
    do_cmd(8'h03); do_wr(8'hFF);
    do_cmd(8'h00); chk("R4 all inverted", rd_data, 8'hF5);
  endtask

  task automatic t_output();
    do_reset();
    pin_in = 4'hA;
    do_cmd(8'h01); do_wr(8'h05);
    chk("R5 flop readback", rd_data, 8'hF5);
    chk("R5 inputs not driven", {4'h0, pin_oe}, 8'h00);
    do_cmd(8'h03); do_wr(8'hFC);
    chk("R6 oe", {4'h0, pin_oe}, 8'h03);
    chk("R5 pin_out low bits", {6'd0, pin_out[1:0]}, 8'h01);
    do_wr(8'h00);
    chk("R6 all out", {4'h0, pin_oe}, 8'h0F);
    chk("R10 dir upper", rd_data, 8'hF0);
    do_cmd(8'h02); do_wr(8'hFF);
    chk("R10 inv upper", rd_data, 8'h0F);
  endtask

  task automatic t_special();
    do_reset();
    do_cmd(8'h50); do_wr(8'h40);
    chk("R7 pullup off", {7'd0, pullup_en}, 8'h00);
    chk("R7 readback", rd_data, 8'h40);
    do_wr(8'h7F);
    chk("R10 special low bits", rd_data, 8'h40);
    do_wr(8'h00);
    chk("R7 pullup on", {7'd0, pullup_en}, 8'h01);
  endtask

  task automatic t_alert();
    do_reset();
    do_cmd(8'h50); do_wr(8'h80);
    chk("R8 idle released", {7'd0, pin_oe[3]}, 8'h00);
    chk("R8 level low", {7'd0, pin_out[3]}, 8'h00);
    chk("R8 pullup still on", {7'd0, pullup_en}, 8'h01);
    pin_in = 4'hD; @(negedge clk);
    chk("R8 alert on change", {7'd0, pin_oe[3]}, 8'h01);
    do_cmd(8'h00);
    chk("R8 still pending", {7'd0, pin_oe[3]}, 8'h01);
    do_rd();
    chk("R8 released by read", {7'd0, pin_oe[3]}, 8'h00);
    pin_in = 4'h5; @(negedge clk);
    chk("R8 pin3 ignored", {7'd0, pin_oe[3]}, 8'h00);
    pin_in = 4'h4; @(negedge clk);
    chk("R8 alert again", {7'd0, pin_oe[3]}, 8'h01);
  endtask

  task automatic t_unknown();
    do_reset();
    do_cmd(8'h22);
    chk("R9 unknown read", rd_data, 8'hFF);
    do_wr(8'h00);
    do_cmd(8'h01); chk("R9 out untouched", rd_data, 8'hFF);
    do_cmd(8'h02); chk("R9 inv untouched", rd_data, 8'h00);
    do_cmd(8'h03); chk("R9 dir untouched", rd_data, 8'hFF);
    do_cmd(8'h50); chk("R9 special untouched", rd_data, 8'h00);
  endtask

  initial begin
    t_reset();
    t_input();
    t_polarity();
    t_output();
    t_special();
    t_alert();
    t_unknown();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule